// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block is the software-visible configuration store of an interrupt router with a parameterised number of input pins (24 by default). It sits behind two bus addresses: an 8-bit selector and a 32-bit data window. The selector value decides what a window access reaches: the identifier register, the version register, the arbitration alias of the identifier, or one 32-bit half of a 64-bit steering entry for a single pin.

Each steering entry carries the vector, the delivery mode, the destination mode, a delivery-status flag, the pin polarity, a remote-IRR flag, the trigger mode, a mask and an 8-bit destination. The whole table is exported as a flat vector to the delivery logic, which reports back through per-pin set and clear strobes for the remote-IRR flag. The bus write path cannot change the two status flags. An entry that is in edge mode never holds a remote-IRR flag.

Top module: `irq_redir_regs`

## Requirements
- R1: A write to bus offset 0x00 loads wdata_i[7:0] into the selector. A read of offset 0x00 returns the selector in bits 7:0 with zeros above it. The selector is 0 after reset.
- R2: The data window is at bus offset 0x10. A read of any offset other than 0x00 and 0x10 returns zero. A write to any such offset changes no state.
- R3: With selector 0x01, a window read returns (pin count − 1) in bits 23:16 and the version code in bits 7:0, with the other bits zero. This is 0x00170011 at the defaults. A window write with this selector is ignored.
- R4: With selector 0x00, a window write stores wdata_i[27:24] as the 4-bit identifier. A read with selector 0x00 or 0x02 returns the identifier in bits 27:24 and zero elsewhere. A window write with selector 0x02 is ignored.
- R5: A selector of 0x10 or above addresses entry (selector − 0x10) >> 1. An odd selector reaches entry bits 63:32 and an even selector reaches bits 31:0.
- R6: A selector from 0x03 to 0x0F, or one whose entry index is at or past the pin count (0x40 and above at the defaults), reads as 0xFFFFFFFF. A window write with such a selector changes no entry.
- R7: Entry layout: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger mode 15 (1 = level), mask 16, destination 63:56. Other bits are stored as written. A window write keeps the existing bits 14 and 12 whatever the data holds. Bit 12 stays 0.
- R8: When an entry's trigger bit is 0 (edge), its remote-IRR bit is 0. This holds right after a write that selects edge mode and while set strobes arrive.
- R9: For a level entry, rirr_set_i[p] sets bit 14 of entry p and rirr_clr_i[p] clears it, one clock later. When both strobes are high, the set wins.
- R10: Reset leaves every entry at 0x0000_0000_0001_0000, with only the mask bit set, and clears the identifier.
- R11: tbl_o[64p+63:64p] holds entry p. A write or strobe is visible there one clock after the edge that samples it.
- R12: rdata_o is loaded on the clock edge that samples rd_en_i high and holds its value while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 8 | Low byte of the bus address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Registered bus read data |
| rirr_set_i | input | NPINS | Per-pin remote-IRR set strobes from the delivery logic |
| rirr_clr_i | input | NPINS | Per-pin remote-IRR clear strobes from the delivery logic |
| tbl_o | output | NPINS*64 | Flat copy of all steering entries |

## Verification
Every state change sits one register away from the edge that samples its strobe, so selector, identifier and entry updates take effect after one clock. The bench drives each strobe for exactly one cycle between falling edges. It then starts the next access only after that edge, and it reads tbl_o at the following falling edge. Read data comes one clock after rd_en_i. The bench therefore compares rdata_o at the falling edge that ends the read strobe and never in the same cycle as the request. The held-value case is checked after a later write with no read in between.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int ENT_W = 64;

  // bit positions inside one steering entry
  localparam int B_DSTAT = 12;
  localparam int B_RIRR  = 14;
  localparam int B_TRIG  = 15;
  localparam int B_MASK  = 16;

  // selector codes for the non-entry registers
  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_ENT0 = 8'h10;

  localparam logic [ENT_W-1:0] ENT_RESET = 64'h0000_0000_0001_0000;

  // entry index addressed by a selector value (wraps for values below 0x10)
  function automatic logic [7:0] ent_index(input logic [7:0] sel);
    logic [7:0] d;
    d = sel - SEL_ENT0;
    return {1'b0, d[7:1]};
  endfunction

  // next entry value: bus write into one half, status bits kept, strobes, edge rule
  function automatic logic [ENT_W-1:0] ent_next(
      input logic [ENT_W-1:0] cur,
      input logic             wr_lo,
      input logic             wr_hi,
      input logic [31:0]      wd,
      input logic             set_r,
      input logic             clr_r);
    logic [ENT_W-1:0] n;
    n = cur;
    if (wr_lo) n[31:0]  = wd;
    if (wr_hi) n[63:32] = wd;
    n[B_DSTAT] = cur[B_DSTAT];
    n[B_RIRR]  = cur[B_RIRR];
    if (set_r)      n[B_RIRR] = 1'b1;
    else if (clr_r) n[B_RIRR] = 1'b0;
    if (!n[B_TRIG]) n[B_RIRR] = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/irq_redir_sel.sv
module irq_redir_sel
  import irq_redir_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_wr,
  input  logic [7:0] sel_wd,
  output logic [7:0] sel_q,
  output logic [7:0] ent_idx,
  output logic       ent_hi,
  output logic       ent_hit,
  output logic       bad_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= sel_wd;
  end

  logic is_named;
  assign is_named = (sel_q == SEL_ID) || (sel_q == SEL_VER) || (sel_q == SEL_ARB);
  assign ent_idx  = ent_index(sel_q);
  assign ent_hi   = sel_q[0];
  assign ent_hit  = (sel_q >= SEL_ENT0) && (int'(ent_idx) < NPINS);
  assign bad_sel  = !is_named && !ent_hit;

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_q == $past(sel_wd)));  // R1
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q));  // R1
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wd,
  input  logic             set_r,
  input  logic             clr_r,
  output logic [ENT_W-1:0] ent_q
);
  logic [ENT_W-1:0] ent_n;
  assign ent_n = ent_next(ent_q, wr_lo, wr_hi, wd, set_r, clr_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_q <= ENT_RESET;
    else        ent_q <= ent_n;
  end

  logic wr_any;
  assign wr_any = wr_lo || wr_hi;

  AST_EDGE_NO_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_q[B_TRIG] |-> !ent_q[B_RIRR]);  // R8
  AST_DSTAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_q[B_DSTAT]);  // R7
  AST_RO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi || (wr_lo && wd[B_TRIG])) && !set_r && !clr_r |=> $stable(ent_q[B_RIRR]));  // R7
  AST_RIRR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_r && ent_q[B_TRIG] && !wr_any |=> ent_q[B_RIRR]);  // R9
  AST_RIRR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_r && !set_r && !wr_any |=> !ent_q[B_RIRR]);  // R9
  AST_NO_WR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> (ent_q[63:B_RIRR+1] == $past(ent_q[63:B_RIRR+1])));  // R11
endmodule

// File: rtl/irq_redir_rdmux.sv
module irq_redir_rdmux
  import irq_redir_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11,
  parameter logic [7:0] SEL_OFS = 8'h00,
  parameter logic [7:0] WIN_OFS = 8'h10
) (
  input  logic [7:0]             addr,
  input  logic [7:0]             sel_q,
  input  logic [3:0]             id_q,
  input  logic [7:0]             ent_idx,
  input  logic                   ent_hi,
  input  logic                   ent_hit,
  input  logic [NPINS*ENT_W-1:0] tbl,
  output logic [31:0]            rd_val
);
  localparam logic [7:0] LAST_PIN = 8'(NPINS - 1);

  logic [31:0] win_val;
  always_comb begin
    win_val = '1;
    if (sel_q == SEL_ID || sel_q == SEL_ARB) begin
      win_val = {4'h0, id_q, 24'h0};
    end else if (sel_q == SEL_VER) begin
      win_val = {8'h00, LAST_PIN, 8'h00, VERSION};
    end else if (ent_hit) begin
      if (ent_hi) win_val = tbl[int'(ent_idx)*ENT_W + 32 +: 32];
      else        win_val = tbl[int'(ent_idx)*ENT_W +: 32];
    end
  end

  always_comb begin
    if (addr == SEL_OFS)      rd_val = {24'h0, sel_q};
    else if (addr == WIN_OFS) rd_val = win_val;
    else                      rd_val = '0;
  end
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11,
  parameter logic [7:0] SEL_OFS = 8'h00,
  parameter logic [7:0] WIN_OFS = 8'h10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [7:0]             addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  input  logic [NPINS-1:0]       rirr_set_i,
  input  logic [NPINS-1:0]       rirr_clr_i,
  output logic [NPINS*ENT_W-1:0] tbl_o
);
  logic       sel_wr, win_wr;
  logic [7:0] sel_q, ent_idx;
  logic       ent_hi, ent_hit, bad_sel;
  logic [3:0] id_q;
  logic [31:0] rd_val;

  assign sel_wr = wr_en_i && (addr_i == SEL_OFS);
  assign win_wr = wr_en_i && (addr_i == WIN_OFS);

  irq_redir_sel #(.NPINS(NPINS)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wd(wdata_i[7:0]),
    .sel_q(sel_q), .ent_idx(ent_idx), .ent_hi(ent_hi), .ent_hit(ent_hit),
    .bad_sel(bad_sel)
  );

  logic id_wr;
  assign id_wr = win_wr && (sel_q == SEL_ID);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (id_wr) id_q <= wdata_i[27:24];
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_ent
    logic hit_p;
    assign hit_p = win_wr && ent_hit && (int'(ent_idx) == p);
    irq_redir_entry u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(hit_p && !ent_hi), .wr_hi(hit_p && ent_hi), .wd(wdata_i),
      .set_r(rirr_set_i[p]), .clr_r(rirr_clr_i[p]),
      .ent_q(tbl_o[p*ENT_W +: ENT_W])
    );
  end

  irq_redir_rdmux #(.NPINS(NPINS), .VERSION(VERSION), .SEL_OFS(SEL_OFS), .WIN_OFS(WIN_OFS)) u_rd (
    .addr(addr_i), .sel_q(sel_q), .id_q(id_q), .ent_idx(ent_idx), .ent_hi(ent_hi),
    .ent_hit(ent_hit), .tbl(tbl_o), .rd_val(rd_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  logic quiet_dlv;
  assign quiet_dlv = (rirr_set_i == '0) && (rirr_clr_i == '0);

  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr && bad_sel && quiet_dlv |=> $stable(tbl_o));  // R6
  AST_ID_ONLY_SEL0: assert property (@(posedge clk) disable iff (!rst_n)
    !id_wr |=> $stable(id_q));  // R4
  AST_OTHER_OFS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && addr_i != SEL_OFS && addr_i != WIN_OFS && quiet_dlv |=> $stable(tbl_o) && $stable(sel_q));  // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));  // R12
endmodule

// File: tb/irq_redir_regs_tb.sv
module irq_redir_regs_tb_top;
  localparam int NP = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] rset = '0, rclr = '0;
  logic [NP*64-1:0] tbl;

  always #2 clk = ~clk;  // 250 MHz

  irq_redir_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rirr_set_i(rset), .rirr_clr_i(rclr), .tbl_o(tbl)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [NP-1:0] s, input logic [NP-1:0] c);
    @(negedge clk); rset = s; rclr = c;
    @(negedge clk); rset = '0; rclr = '0;
  endtask

  typedef struct packed {
    logic [7:0]  sel;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{8'h10, 32'h0000_80A5, 32'h0000_80A5, 8'd5},   // R5 pin0 low, level
    '{8'h11, 32'hFF00_0000, 32'hFF00_0000, 8'd5},   // R5 pin0 high
    '{8'h12, 32'h0000_5FFF, 32'h0000_0FFF, 8'd7},   // R7 status bits kept at 0
    '{8'h3F, 32'h1234_5678, 32'h1234_5678, 8'd5},   // R5 last pin high
    '{8'h2E, 32'h0001_A0FF, 32'h0001_A0FF, 8'd5},   // R5 pin15 low
    '{8'h40, 32'h0000_DEAD, 32'hFFFF_FFFF, 8'd6},   // R6 past last pin
    '{8'h05, 32'h0000_BEEF, 32'hFFFF_FFFF, 8'd6},   // R6 gap selector
    '{8'h01, 32'h0000_0000, 32'h0017_0011, 8'd3},   // R3 version
    '{8'h00, 32'hA5FF_FFFF, 32'h0500_0000, 8'd4},   // R4 identifier
    '{8'h02, 32'h0F00_0000, 32'h0500_0000, 8'd4}    // R4 arbitration alias
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [NP*64-1:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state: R10, R1
    bus_rd(8'h00); chk("R1 reset selector", rdata, 32'h0);
    bus_rd(8'h10); chk("R10 reset identifier", rdata, 32'h0);
    for (int p = 0; p < NP; p++) begin
      checks++;
      if (tbl[p*64 +: 64] !== 64'h0000_0000_0001_0000) begin
        errors++;
        $display("FAIL R10 entry %0d: actual %h expected %h", p, tbl[p*64 +: 64], 64'h10000);
      end
    end

    // vector table walk
    for (int i = 0; i < 10; i++) begin
      bus_wr(8'h00, {24'h0, VEC[i].sel});
      bus_wr(8'h10, VEC[i].wd);
      bus_rd(8'h10);
      chk($sformatf("R%0d vec %0d", VEC[i].req, i), rdata, VEC[i].exp);
    end

    // R11 exported table
    @(negedge clk);
    chk("R11 pin0 high", tbl[63:32], 32'hFF00_0000);
    chk("R11 pin23 high", tbl[23*64+32 +: 32], 32'h1234_5678);
    chk("R11 pin5 untouched", tbl[5*64 +: 32], 32'h0001_0000);

    // R6 discarded write leaves table unchanged
    snap = tbl;
    bus_wr(8'h00, 32'h0000_0041);
    bus_wr(8'h10, 32'h0000_FFFF);
    @(negedge clk);
    checks++;
    if (tbl !== snap) begin errors++; $display("FAIL R6 table changed: actual %h expected %h", tbl[31:0], snap[31:0]); end

    // R1 selector readback, R2 other offsets
    bus_rd(8'h00); chk("R1 selector readback", rdata, 32'h0000_0041);
    bus_wr(8'h20, 32'h0000_0055);
    bus_rd(8'h00); chk("R2 stray write ignored", rdata, 32'h0000_0041);
    bus_rd(8'h20); chk("R2 stray offset reads 0", rdata, 32'h0);
    bus_rd(8'h04); chk("R2 offset 04 reads 0", rdata, 32'h0);

    // R3 version write ignored
    bus_wr(8'h00, 32'h0000_0001);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10); chk("R3 version after write", rdata, 32'h0017_0011);

    // R12 hold
    bus_wr(8'h00, 32'h0000_0010);
    chk("R12 rdata held", rdata, 32'h0017_0011);

    // R9 / R7 / R8 remote IRR on pin0 (level, vector A5)
    pulse(24'h1, 24'h0);
    bus_rd(8'h10); chk("R9 set on level", rdata, 32'h0000_C0A5);
    bus_wr(8'h10, 32'h0000_80A5);
    bus_rd(8'h10); chk("R7 remote IRR kept on write", rdata, 32'h0000_C0A5);
    pulse(24'h0, 24'h1);
    bus_rd(8'h10); chk("R9 clear", rdata, 32'h0000_80A5);
    pulse(24'h1, 24'h1);
    bus_rd(8'h10); chk("R9 set wins", rdata, 32'h0000_C0A5);
    bus_wr(8'h10, 32'h0000_00A5);
    bus_rd(8'h10); chk("R8 edge write clears", rdata, 32'h0000_00A5);
    pulse(24'h1, 24'h0);
    bus_rd(8'h10); chk("R8 set ignored on edge", rdata, 32'h0000_00A5);
    @(negedge clk);
    chk("R11 pin0 low export", tbl[31:0], 32'h0000_00A5);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule